// File: doc/BRIEF.md
# Pipelined Heavy-Hitter Flow Table

This block keeps approximate per-flow packet counts for the largest flows on a link. It has a fixed number of pipelined stages, and each stage owns a small table of (flow ID, count) entries. A packet's flow ID is hashed separately for every stage, and each stage touches exactly one entry. If some stage already tracks the flow, that entry's count goes up by one. If no stage tracks it, the pipeline carries forward the smallest count it has seen and the stage holding it.

When a packet leaves the last stage without a match, a power-of-two coin is flipped. Its probability of heads is close to the inverse of (minimum + 1). On heads the block raises a replacement request carrying:
- the flow ID,
- the target stage,
- the new count,
- the ID that occupied the entry when it was observed.

The surrounding logic feeds the request back through the replacement input. There it overwrites the entry, but only if the entry still holds the observed ID. The packet itself always leaves the block unchanged, after a fixed latency. Empty entries start at a count of 100, so replacements stay rare.

Top module: `hh_table`

## Requirements
- R1: After reset, no output packet and no request is presented. Every entry is empty, holding flow ID 0 and a count of 100.
- R2: Every input packet appears at the output with the same ID exactly STAGES cycles after it is presented, whether or not a request is raised.
- R3: In stage s, a packet uses one entry. Its index is the XOR of the 6-bit chunks of (ID xor ((s+1)*0x9E3779B9 mod 2^32)). Chunk k is bits [6k+5:6k], and the last chunk is bits [31:30] zero-extended.
- R4: If a stage holds the packet's ID, the earliest such stage increments that count, saturating at 65535. The output then shows hit=1, that stage, and the new count. Later stages are left untouched and no request is raised.
- R5: On a miss, the output shows hit=0, the smallest count among the visited entries and its stage. The earliest stage wins a tie.
- R6: On a miss, N = floor(log2(min+1)), and a request is raised only if the low N bits of the random register are all 1 (N=0 always raises one). The random register is a 32-bit shifter seeded to 0xACE10001 at reset. Every cycle it shifts right and XORs in 0x80200003 when the bit shifted out is 1. Its value in the cycle the packet is at the output is the one used.
- R7: A request carries the packet ID, the minimum's stage, the count min+1 (saturating at 65535), and the ID held by the minimum entry (0 if the entry is empty).
- R8: A replacement input writes its ID and count into its stage, at that ID's index in that stage. The write happens only if the entry currently holds the stated old ID; otherwise the replacement is discarded.
- R9: A replacement is discarded if, in the same cycle, a packet increments the same entry. The packet's increment takes effect.
- R10: A packet with flow ID 0 passes through with hit=0, touches no entry and never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet present |
| in_id | input | 32 | Packet flow ID |
| rc_valid | input | 1 | Replacement present |
| rc_id | input | 32 | Flow ID to install |
| rc_stage | input | 1 | Stage to write |
| rc_cnt | input | 16 | Count to install |
| rc_old | input | 32 | ID the entry must still hold |
| out_valid | output | 1 | Packet leaving |
| out_id | output | 32 | Its flow ID |
| out_hit | output | 1 | Flow was found |
| out_stage | output | 1 | Hit stage, or minimum stage on a miss |
| out_cnt | output | 16 | New count on a hit, minimum on a miss |
| rq_valid | output | 1 | Replacement request |
| rq_id | output | 32 | Flow ID to install |
| rq_stage | output | 1 | Stage of the minimum |
| rq_cnt | output | 16 | Count to install |
| rq_old | output | 32 | ID observed in the minimum entry |

## Verification
The hardest situations to reach are a deterministic request and a stale or colliding replacement. With default counts the coin lands heads only about once in 64 packets. The bench therefore searches its own hash for an ID that lands on a chosen entry of a chosen stage. It installs that ID directly with a tiny count through the replacement port, which forces a known minimum with N of 0 or 1. It also drives a replacement in the same cycle as a packet that increments the same entry. Every request outcome is predicted from the bench's own model of the random register.

// File: rtl/hh_table.sv
module hh_table #(
  parameter int          STAGES    = 2,
  parameter int          ID_W      = 32,
  parameter int          CNT_W     = 16,
  parameter int          IDX_W     = 6,
  parameter int          INIT_CNT  = 100,
  parameter logic [31:0] LFSR_SEED = 32'hACE1_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ID_W-1:0]  in_id,
  input  logic             rc_valid,
  input  logic [ID_W-1:0]  rc_id,
  input  logic [(STAGES>1?$clog2(STAGES):1)-1:0] rc_stage,
  input  logic [CNT_W-1:0] rc_cnt,
  input  logic [ID_W-1:0]  rc_old,
  output logic             out_valid,
  output logic [ID_W-1:0]  out_id,
  output logic             out_hit,
  output logic [(STAGES>1?$clog2(STAGES):1)-1:0] out_stage,
  output logic [CNT_W-1:0] out_cnt,
  output logic             rq_valid,
  output logic [ID_W-1:0]  rq_id,
  output logic [(STAGES>1?$clog2(STAGES):1)-1:0] rq_stage,
  output logic [CNT_W-1:0] rq_cnt,
  output logic [ID_W-1:0]  rq_old
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int SW     = STAGES > 1 ? $clog2(STAGES) : 1;
  localparam int CHUNKS = (ID_W + IDX_W - 1) / IDX_W;
  localparam int LAST   = STAGES - 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [IDX_W-1:0] slot(input logic [ID_W-1:0] v, input int s);
    logic [ID_W-1:0]  x;
    logic [IDX_W-1:0] f;
    x = v ^ ID_W'((s + 1) * 32'h9E37_79B9);
    f = '0;
    for (int k = 0; k < CHUNKS; k++) f ^= IDX_W'(x >> (k * IDX_W));
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == CMAX) ? c : c + 1'b1;
  endfunction

  logic [31:0] lfsr;
  always_ff @(posedge clk)
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= (lfsr >> 1) ^ (lfsr[0] ? 32'h8020_0003 : 32'h0);

  logic             q_v   [STAGES];
  logic             q_hit [STAGES];
  logic [ID_W-1:0]  q_id  [STAGES];
  logic [ID_W-1:0]  q_old [STAGES];
  logic [SW-1:0]    q_st  [STAGES];
  logic [CNT_W-1:0] q_cnt [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [ID_W-1:0]  tid  [DEPTH];
    logic [CNT_W-1:0] tcnt [DEPTH];
    logic             c_v, c_hit;
    logic [ID_W-1:0]  c_id, c_old;
    logic [SW-1:0]    c_st;
    logic [CNT_W-1:0] c_cnt;
    logic             r_v, r_hit;
    logic [ID_W-1:0]  r_id, r_old;
    logic [SW-1:0]    r_st;
    logic [CNT_W-1:0] r_cnt;

    if (s == 0) begin : g_head
      assign c_v = in_valid;  assign c_id = in_id;  assign c_hit = 1'b0;
      assign c_st = '0;       assign c_cnt = CMAX;  assign c_old = '0;
    end else begin : g_link
      assign c_v = q_v[s-1];  assign c_id = q_id[s-1];  assign c_hit = q_hit[s-1];
      assign c_st = q_st[s-1]; assign c_cnt = q_cnt[s-1]; assign c_old = q_old[s-1];
    end

    wire [IDX_W-1:0] idx   = slot(c_id, s);
    wire [IDX_W-1:0] ridx  = slot(rc_id, s);
    wire             look  = c_v && (c_id != '0) && !c_hit;
    wire             match = look && (tid[idx] == c_id);
    wire             lower = look && !match && ((s == 0) || (tcnt[idx] < c_cnt));
    wire             take  = rc_valid && (rc_stage == SW'(s)) && (tid[ridx] == rc_old)
                             && !(match && (ridx == idx));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) begin
          tid[i]  <= '0;
          tcnt[i] <= CNT_W'(INIT_CNT);
        end
      end else begin
        if (match) tcnt[idx] <= bump(tcnt[idx]);
        if (take) begin
          tid[ridx]  <= rc_id;
          tcnt[ridx] <= rc_cnt;
        end
      end
    end

    always_ff @(posedge clk) begin
      r_v   <= rst_n && c_v;
      r_id  <= c_id;
      r_hit <= c_hit || match;
      r_st  <= (match || lower) ? SW'(s) : c_st;
      r_cnt <= match ? bump(tcnt[idx]) : (lower ? tcnt[idx] : c_cnt);
      r_old <= lower ? tid[idx] : c_old;
    end

    assign q_v[s] = r_v;   assign q_id[s] = r_id;   assign q_hit[s] = r_hit;
    assign q_st[s] = r_st; assign q_cnt[s] = r_cnt; assign q_old[s] = r_old;
  end

  assign out_valid = q_v[LAST];
  assign out_id    = q_id[LAST];
  assign out_hit   = q_hit[LAST];
  assign out_stage = q_st[LAST];
  assign out_cnt   = q_cnt[LAST];

  logic [CNT_W:0] m1;
  logic [31:0]    need;
  logic           heads;
  assign m1 = {1'b0, out_cnt} + 1'b1;
  always_comb begin
    int n;
    n = 0;
    for (int b = 0; b <= CNT_W; b++) if (m1[b]) n = b;
    for (int b = 0; b < 32; b++) need[b] = (b < n);
    heads = ((lfsr & need) == need);
  end

  assign rq_valid = out_valid && (out_id != '0) && !out_hit && heads;
  assign rq_id    = out_id;
  assign rq_stage = out_stage;
  assign rq_cnt   = bump(out_cnt);
  assign rq_old   = q_old[LAST];
endmodule

module hh_table_chk #(
  parameter int ID_W  = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic [ID_W-1:0]  out_id,
  input logic             out_hit,
  input logic [CNT_W-1:0] out_cnt,
  input logic             rq_valid
);
  // R7
  rq_with_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> (out_valid && !out_hit));
  // R10
  zero_id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_id == '0) |-> (!out_hit && !rq_valid));
  // R6
  sure_coin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_id != '0 && !out_hit && out_cnt == '0) |-> rq_valid);
  // R4
  hit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_cnt != '0));
  // R10
  rq_nonzero_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> (out_id != '0));
endmodule

bind hh_table hh_table_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_id(out_id),
  .out_hit(out_hit), .out_cnt(out_cnt), .rq_valid(rq_valid)
);

// File: tb/hh_table_bench.sv
module hh_table_bench;
  localparam int NS = 2;
  localparam int SWB = NS > 1 ? $clog2(NS) : 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 0, rc_valid = 0;
  logic [31:0] in_id = 0, rc_id = 0, rc_old = 0;
  logic [SWB-1:0] rc_stage = 0;
  logic [15:0] rc_cnt = 0;
  logic out_valid, out_hit, rq_valid;
  logic [31:0] out_id, rq_id, rq_old;
  logic [SWB-1:0] out_stage, rq_stage;
  logic [15:0] out_cnt, rq_cnt;

  hh_table #(.STAGES(NS)) u_hh_table (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
    .rc_valid(rc_valid), .rc_id(rc_id), .rc_stage(rc_stage), .rc_cnt(rc_cnt), .rc_old(rc_old),
    .out_valid(out_valid), .out_id(out_id), .out_hit(out_hit), .out_stage(out_stage),
    .out_cnt(out_cnt), .rq_valid(rq_valid), .rq_id(rq_id), .rq_stage(rq_stage),
    .rq_cnt(rq_cnt), .rq_old(rq_old));

  int n_chk = 0, n_bad = 0;
  logic [31:0] bl;
  logic [31:0] mid [NS][64];
  logic [15:0] mcnt [NS][64];

  // random register model per R6
  always @(posedge clk)
    if (!rst_n) bl <= 32'hACE1_0001;
    else bl <= bl[0] ? ((bl >> 1) ^ 32'h8020_0003) : (bl >> 1);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bh(input logic [31:0] id, input int s);
    logic [31:0] x = id ^ ((s + 1) * 32'h9E37_79B9);
    int r = 0;
    for (int k = 0; k < 6; k++) r = r ^ ((x >> (6 * k)) & 63);
    return r;
  endfunction

  function automatic logic [15:0] inc16(input logic [15:0] c);
    return (c == 16'hFFFF) ? c : c + 16'd1;
  endfunction

  function automatic logic [31:0] collide(input logic [31:0] base, input int s, input int ix);
    logic [31:0] c = base;
    while (bh(c, s) != ix) c++;
    return c;
  endfunction

  task automatic model_rc(input logic [31:0] id, input int s, input logic [15:0] c, input logic [31:0] old);
    int ix = bh(id, s);
    if (mid[s][ix] == old) begin mid[s][ix] = id; mcnt[s][ix] = c; end
  endtask

  // called at a negedge; leaves at a negedge
  task automatic rc_drive(input logic [31:0] id, input int s, input logic [15:0] c, input logic [31:0] old);
    rc_valid = 1; rc_id = id; rc_stage = SWB'(s); rc_cnt = c; rc_old = old;
    model_rc(id, s, c, old);
    @(negedge clk);
    rc_valid = 0;
  endtask

  task automatic pkt(input logic [31:0] id, input bit feed, input string tag);
    bit e_hit = 0, e_rq;
    int e_st = 0, n = 0;
    logic [15:0] e_cnt = 16'hFFFF;
    logic [31:0] e_old = 0, need = 0;
    logic [16:0] m1;
    if (id != 0)
      for (int s = 0; s < NS; s++) begin
        int ix = bh(id, s);
        if (!e_hit) begin
          if (mid[s][ix] == id) begin
            e_hit = 1; e_st = s; mcnt[s][ix] = inc16(mcnt[s][ix]); e_cnt = mcnt[s][ix];
          end else if (s == 0 || mcnt[s][ix] < e_cnt) begin
            e_cnt = mcnt[s][ix]; e_st = s; e_old = mid[s][ix];
          end
        end
      end
    in_valid = 1; in_id = id;
    @(negedge clk);
    in_valid = 0;
    repeat (NS - 1) @(negedge clk);
    m1 = {1'b0, e_cnt} + 17'd1;
    for (int b = 0; b <= 16; b++) if (m1[b]) n = b;
    for (int b = 0; b < 32; b++) need[b] = (b < n);
    e_rq = (id != 0) && !e_hit && ((bl & need) == need);
    check({tag, " R2 out_valid"}, out_valid, 1);
    check({tag, " R2 out_id"}, out_id, id);
    if (id == 0) begin
      check({tag, " R10 hit"}, out_hit, 0);
      check({tag, " R10 rq"}, rq_valid, 0);
    end else begin
      check({tag, e_hit ? " R4 hit" : " R5 hit"}, out_hit, e_hit);
      check({tag, e_hit ? " R4 stage" : " R5 stage"}, out_stage, e_st);
      check({tag, e_hit ? " R4 cnt" : " R5 cnt"}, out_cnt, e_cnt);
      check({tag, " R6 rq"}, rq_valid, e_rq);
      if (e_rq) begin
        check({tag, " R7 id"}, rq_id, id);
        check({tag, " R7 stage"}, rq_stage, e_st);
        check({tag, " R7 cnt"}, rq_cnt, inc16(e_cnt));
        check({tag, " R7 old"}, rq_old, e_old);
        if (feed) rc_drive(id, e_st, inc16(e_cnt), e_old);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < 64; i++) begin mid[s][i] = 0; mcnt[s][i] = 16'd100; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 rq_valid after reset", rq_valid, 0);
    @(negedge clk);
    check("R1 idle output", out_valid, 0);
  endtask

  task automatic t_fresh;
    pkt(32'h0000_1234, 0, "fresh flow R1");
    pkt(32'h00AB_CDEF, 0, "second fresh flow");
    @(negedge clk);
    check("R2 no stray output", out_valid, 0);
  endtask

  task automatic t_install_and_hit;
    logic [31:0] f = 32'h5000_0001;
    rc_drive(f, 1, 16'd5, 0);
    pkt(f, 0, "installed R8 hit");
    pkt(f, 0, "installed R8 hit again");
    rc_drive(f, 0, 16'hFFFE, 0);
    pkt(f, 0, "stage0 wins R4");
    pkt(f, 0, "saturate R4");
  endtask

  task automatic t_stale;
    logic [31:0] f = 32'h7000_0042;
    rc_drive(f, 0, 16'd3, 32'hDEAD_BEEF);
    pkt(f, 0, "stale discarded R8");
  endtask

  task automatic t_forced_min;
    logic [31:0] x = 32'h6100_0000, y, z;
    y = collide(32'h6200_0000, 1, bh(x, 1));
    rc_drive(y, 1, 16'd0, 0);
    pkt(x, 1, "zero min R6 sure");
    pkt(x, 0, "after replace R8");
    z = collide(32'h6300_0000, 0, bh(32'h6400_0000, 0));
    rc_drive(z, 0, 16'd1, mid[0][bh(z, 0)]);
    pkt(32'h6400_0000, 0, "min one R6 coin");
    pkt(32'h6400_0000, 0, "min one R6 coin again");
  endtask

  task automatic t_conflict;
    logic [31:0] a = 32'h4400_0007;
    rc_drive(a, 0, 16'd10, mid[0][bh(a, 0)]);
    in_valid = 1; in_id = a;
    rc_valid = 1; rc_id = a; rc_stage = 0; rc_cnt = 16'd500; rc_old = a;
    mcnt[0][bh(a, 0)] = 16'd11;
    @(negedge clk);
    in_valid = 0; rc_valid = 0;
    repeat (NS - 1) @(negedge clk);
    check("conflict R9 hit", out_hit, 1);
    check("conflict R9 cnt", out_cnt, 16'd11);
    pkt(a, 0, "conflict follow-up R9");
  endtask

  task automatic t_zero;
    pkt(32'h0, 0, "id zero R10");
  endtask

  task automatic t_mix;
    for (int i = 0; i < 300; i++)
      pkt(32'h0900_0000 + 32'((i * 7) % 11) * 32'h0001_0101, 1, "mix R3");
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fresh();
    t_install_and_hit();
    t_stale();
    t_forced_min();
    t_conflict();
    t_zero();
    t_mix();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule